// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital heart of a 12-bit sampling converter. It watches three control inputs (an active-high enable, an active-low select and an active-low read/convert strobe). It treats the moment all three become active together as a single start event. On that event it captures a length-select input, clears its working word and raises a busy flag. It then spends a fixed number of clock cycles in acquisition, which is when the analog side samples the input. After that it performs a binary search from the most significant bit downward.

The trial word is presented on `dac_code` for an external capacitor DAC. The external comparator answers on `cmp_below`. When the search ends, the final word is copied to `result`, busy drops and `eoc` pulses for one cycle. A short conversion stops after eight trial bits. The bit that would have been tried next is left set in the result and the remaining bits are zero. Gating of the result onto a shared bus belongs to a separate block.

Top module: `sar_sequencer`

## Requirements
- R1: After synchronous reset, `busy` and `eoc` are 0 and `result` and `dac_code` are all zeros.
- R2: A start occurs only on the clock where `en` is 1, `sel_n` is 0 and `rc_n` is 0 while the previous cycle did not meet all three. With any one of the three inactive, `busy` stays 0.
- R3: The start is caused by whichever of the three inputs becomes active last, and this includes all three changing in the same cycle.
- R4: `busy` rises in the cycle after the start. It stays high for 2 acquisition cycles plus one cycle per trial bit (14 cycles for a full conversion).
- R5: Bits are tried from bit 11 down. The first trial cycle shows `dac_code` = 0x800. A trial bit is kept when `cmp_below` is 1 and cleared when it is 0, and the next lower bit is then set.
- R6: With `len_sel` = 0 at the start, 12 bits are tried and `result` is the full search outcome. Against a comparator that reports 1 when `dac_code` ≤ the input, this equals the input.
- R7: With `len_sel` = 1 at the start, 8 bits (11 down to 4) are tried. `result` then has bit 3 = 1 and bits 2..0 = 0, and `busy` lasts 10 cycles.
- R8: `len_sel` is sampled only at the start. Changing it during a conversion has no effect on the length.
- R9: A start condition that appears while `busy` is 1 neither restarts nor resets the conversion. A condition still held when the conversion ends does not start another one.
- R10: `eoc` is a one-cycle pulse. It appears in the cycle where `busy` first reads 0, with `result` already final.
- R11: At the start the working word is cleared, so `dac_code` is 0 throughout acquisition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable, active high |
| sel_n | input | 1 | Select, active low |
| rc_n | input | 1 | Read/convert strobe, low requests a conversion |
| len_sel | input | 1 | 1 selects a short (8-bit) conversion, captured at start |
| cmp_below | input | 1 | Comparator: 1 when the trial word is not above the input |
| busy | output | 1 | High while a conversion is in progress |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| dac_code | output | 12 | Current trial word for the DAC |
| result | output | 12 | Last completed conversion result |

## Verification
A corrupted bit index or state shows first on `dac_code`. The first trial word or the one after it would be wrong within three to four cycles of the start. A wrong length latch or a retrigger that leaks through changes how long `busy` stays high, so the error appears at the latest 14 cycles after the start. A faulty keep/clear decision reaches `result` and `eoc` at the end of the same conversion. The bench therefore checks the trial words, the busy duration and the final word of every conversion, and it varies which control input arrives last.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACQ   = 2'd1,
    ST_TRIAL = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sel_n,
  input  logic rc_n,
  output logic start
);
  logic cond;
  logic cond_q;

  // All three must be active together; the last to arrive forms the edge.
  assign cond  = en & ~sel_n & ~rc_n;
  assign start = cond & ~cond_q;

  always_ff @(posedge clk) begin
    if (rst) cond_q <= 1'b1;
    else     cond_q <= cond;
  end
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_pkg::*;
#(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             len_sel,
  input  logic             cmp_below,
  output logic             busy,
  output logic             eoc,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] result
);
  localparam int IDX_W     = $clog2(WIDTH);
  localparam int ACQ_W     = $clog2(ACQ_CYCLES + 1);
  localparam int SHORT_END = WIDTH - SHORT_BITS;
  localparam int FILL_POS  = SHORT_END - 1;
  localparam logic [WIDTH-1:0] WORD_ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] MSB_ONE   = WORD_ONE << (WIDTH - 1);
  localparam logic [WIDTH-1:0] FILL_WORD = WORD_ONE << FILL_POS;
  localparam logic [WIDTH-1:0] FILL_MASK = (FILL_WORD << 1) - WORD_ONE;

  seq_state_t       state;
  logic [ACQ_W-1:0] acq_cnt;
  logic [IDX_W-1:0] idx;
  logic             short_q;
  logic [WIDTH-1:0] trial;
  logic [WIDTH-1:0] decided;
  logic [WIDTH-1:0] result_q;
  logic             busy_q;
  logic             eoc_q;
  logic             last_bit;

  always_comb begin
    decided = trial;
    if (!cmp_below) decided[idx] = 1'b0;
  end

  assign last_bit = short_q ? (idx == IDX_W'(SHORT_END)) : (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      acq_cnt  <= '0;
      idx      <= '0;
      short_q  <= 1'b0;
      trial    <= '0;
      result_q <= '0;
      busy_q   <= 1'b0;
      eoc_q    <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_ACQ;
            acq_cnt <= '0;
            trial   <= '0;
            short_q <= len_sel;
            busy_q  <= 1'b1;
          end
        end
        ST_ACQ: begin
          if (acq_cnt == ACQ_W'(ACQ_CYCLES - 1)) begin
            state <= ST_TRIAL;
            idx   <= IDX_W'(WIDTH - 1);
            trial <= MSB_ONE;
          end else begin
            acq_cnt <= acq_cnt + 1'b1;
          end
        end
        ST_TRIAL: begin
          if (last_bit) begin
            result_q <= short_q ? (decided | FILL_WORD) : decided;
            trial    <= decided;
            state    <= ST_IDLE;
            busy_q   <= 1'b0;
            eoc_q    <= 1'b1;
          end else begin
            trial <= decided | (WORD_ONE << (idx - 1'b1));
            idx   <= idx - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign eoc      = eoc_q;
  assign dac_code = trial;
  assign result   = result_q;

  // R11: working word stays cleared through acquisition
  assert_acq_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACQ) |-> (trial == '0));

  // R5: first trial presents only the MSB
  assert_first_trial_msb_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRIAL && $past(state) == ST_ACQ) |-> (trial == MSB_ONE));

  // R5: bits below the one under trial are still zero
  assert_low_bits_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRIAL) |-> ((trial & ((WORD_ONE << idx) - WORD_ONE)) == '0));

  // R7: short result carries the fill bit and zeros beneath it
  assert_short_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (eoc_q && short_q) |-> ((result_q & FILL_MASK) == FILL_WORD));

  // R10: end pulse coincides with busy falling
  assert_eoc_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
    eoc_q |-> (!busy_q && $past(busy_q)));

  // R9: start while busy does not relatch the length
  assert_retrigger_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> $stable(short_q));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             sel_n,
  input  logic             rc_n,
  input  logic             len_sel,
  input  logic             cmp_below,
  output logic             busy,
  output logic             eoc,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] result
);
  logic start;

  sar_start_detect u_start (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .sel_n (sel_n),
    .rc_n  (rc_n),
    .start (start)
  );

  sar_core #(
    .WIDTH      (WIDTH),
    .SHORT_BITS (SHORT_BITS),
    .ACQ_CYCLES (ACQ_CYCLES)
  ) u_core (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .len_sel   (len_sel),
    .cmp_below (cmp_below),
    .busy      (busy),
    .eoc       (eoc),
    .dac_code  (dac_code),
    .result    (result)
  );

  // R2: busy only rises after all three controls were active
  assert_start_gate_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(en) && !$past(sel_n) && !$past(rc_n)));
endmodule

// File: tb/sim_sar_sequencer.sv
module sim_sar_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, sel_n = 1'b1, rc_n = 1'b1, len_sel = 1'b0;
  logic        cmp_below;
  logic        busy, eoc;
  logic [11:0] dac_code, result;
  logic [11:0] vin = '0;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  // comparator model: trial word not above the input
  assign cmp_below = (dac_code <= vin);

  sar_sequencer u0 (
    .clk(clk), .rst(rst), .en(en), .sel_n(sel_n), .rc_n(rc_n),
    .len_sel(len_sel), .cmp_below(cmp_below), .busy(busy), .eoc(eoc),
    .dac_code(dac_code), .result(result)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0: rc_n falls last; 1: en rises last; 2: all at once; 3: rc_n last with retrigger
  task automatic run_conv(input logic [11:0] v, input logic ln, input int mode);
    int k;
    logic [11:0] exp_res;
    exp_res = ln ? ((v & 12'hFF0) | 12'h008) : v;
    @(negedge clk);
    vin = v;
    case (mode)
      1:       begin en = 1'b0; sel_n = 1'b0; rc_n = 1'b0; end
      2:       begin en = 1'b0; sel_n = 1'b1; rc_n = 1'b1; end
      default: begin en = 1'b1; sel_n = 1'b0; rc_n = 1'b1; end
    endcase
    repeat (2) @(negedge clk);
    check("R2 partial condition no start", busy, 0);
    en = 1'b1; sel_n = 1'b0; rc_n = 1'b0; len_sel = ln;
    k = 0;
    forever begin
      @(negedge clk);
      if (!busy || k > 40) break;
      k++;
      if (k == 1 || k == 2) check("R11 dac clear in acquisition", dac_code, 0);
      if (k == 3) check("R5 first trial MSB", dac_code, 12'h800);
      if (k == 4) check("R5 second trial", dac_code, (v & 12'h800) | 12'h400);
      if (k == 2) len_sel = ~ln;  // R8: change after start
      if (mode == 3 && k == 5) rc_n = 1'b1;
      if (mode == 3 && k == 6) rc_n = 1'b0;  // R9: new start edge while busy
    end
    check(ln ? "R7 busy length short" : "R4 busy length full", k, ln ? 10 : 14);
    check("R10 eoc at busy fall", eoc, 1);
    check(ln ? "R7 short result" : "R6 full result", result, exp_res);
    @(negedge clk);
    check("R10 eoc one cycle", eoc, 0);
    repeat (3) @(negedge clk);
    check("R9 held condition no restart", busy, 0);
    check("R9 result stable", result, exp_res);
  endtask

  localparam logic [12:0] VEC [8] = '{
    {1'b0, 12'hA5C}, {1'b0, 12'h000}, {1'b0, 12'hFFF}, {1'b0, 12'h800},
    {1'b0, 12'h7FF}, {1'b1, 12'hFFF}, {1'b1, 12'h00F}, {1'b1, 12'h3C7}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy reset", busy, 0);
    check("R1 eoc reset", eoc, 0);
    check("R1 result reset", result, 0);
    check("R1 dac reset", dac_code, 0);
    for (int i = 0; i < 8; i++) run_conv(VEC[i][11:0], VEC[i][12], 0);
    run_conv(12'h5A3, 1'b0, 1);  // R3 en last
    run_conv(12'h1B6, 1'b1, 2);  // R3 all three together
    run_conv(12'h9E1, 1'b0, 3);  // R9 retrigger while busy
    run_conv(12'h6D2, 1'b1, 3);  // R9 retrigger, short
    // R2: sel_n inactive blocks start
    @(negedge clk);
    en = 1'b1; sel_n = 1'b1; rc_n = 1'b1;
    @(negedge clk);
    rc_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 sel_n high blocks start", busy, 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule